// File: doc/BRIEF.md
# Tagged Empty/Full FIFO Storage Cell

This block is one storage cell of an inter-thread communication unit. It holds a small FIFO of data words and keeps software-visible tag bits next to it: an empty flag, a full flag and a general-purpose flag. A bus decoder outside the block turns each access into a single-cycle request. The request carries a read/write direction, a view code, the ID of the requesting thread and a write word. One cycle later the cell answers with read data and a block indication.

The views provide these accesses:
- raw access, which peeks at the head entry or overwrites the newest entry without moving any pointer;
- access to a packed control word that exposes the tag bits, the occupancy and the configured depth;
- blocking push/pop;
- non-blocking push/pop.

When a blocking access cannot proceed, the cell records the requester's ID in a waiter mask and returns a block response. The next empty/full access that is not blocked pulses `wake_mask` with every recorded waiter and clears the mask. The scheduler that parks and resumes threads is outside the block.

The parameter `FIFO_EN` selects the variant. With `FIFO_EN` = 1 the cell is a FIFO cell. With `FIFO_EN` = 0 it is a non-FIFO cell: the FIFO machinery has no effect and only the tag bits remain.

Top module: `tagged_fifo_cell`

## Requirements
- R1: After reset a FIFO cell has E = 1, F = 0, T = 0, occupancy 0, and a FIFO-mode bit of 1. With the default depth of 8, a control read returns 64'h3002_0001. `wake_mask` and `rsp_block` are 0.
- R2: View code 1 is the control view.
  - A read returns log2(DEPTH) at bits 31:28, the occupancy at bits 27:18, the FIFO-mode bit at 17, T at 16, F at 1 and E at 0. All other bits are 0.
  - A write loads T, F and E from write-data bits 16, 1 and 0 and changes nothing else.
  - If the written bit 0 is 1, the occupancy is also reset to 0.
- R3: View codes 2 (blocking) and 3 (non-blocking) are the empty/full views. An empty/full write that is not blocked:
  - clears E;
  - appends the word when the occupancy is below DEPTH, and otherwise drops it;
  - sets F when the occupancy is then DEPTH.
- R4: An empty/full read that is not blocked:
  - clears F;
  - returns and removes the oldest word when the occupancy is nonzero, and otherwise returns 0;
  - sets E when the occupancy is then 0.
  The head index wraps circularly.
- R5: A blocking write (view 2) with F = 1 clears E, stores nothing and leaves the occupancy unchanged. It returns `rsp_block` = 1 and read data 0, and adds bit `req_id` to the waiter mask.
- R6: A blocking read (view 2) with E = 1 clears F, removes nothing and returns read data 0 with `rsp_block` = 1. It adds bit `req_id` to the waiter mask.
- R7: An empty/full access that is not blocked drives `wake_mask` with the waiter mask for exactly one response cycle and clears the waiter mask. `wake_mask` is 0 in every other response cycle and never coincides with `rsp_block`.
- R8: View code 0 is the raw view. A raw read returns the head entry and changes neither the occupancy nor the head.
- R9: A raw write overwrites the most recently appended entry when the occupancy is nonzero and has no effect when it is 0.
- R10: With `FIFO_EN` = 0, the cell behaves as follows:
  - A reset leaves E, F and T at 0.
  - Empty/full and raw reads return 0. Empty/full and raw writes are ignored.
  - No access blocks or wakes.
  - A control read shows only T, F and E.
- R11: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1. View codes 4 to 7 return read data 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 3 | 0 raw, 1 control, 2 blocking empty/full, 3 non-blocking empty/full |
| req_id | input | $clog2(REQ_N) | Requester ID |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Read data |
| rsp_block | output | 1 | Blocking access could not proceed |
| wake_mask | output | REQ_N | One-cycle pulse of woken requester IDs |

## Verification
The hardest situation to reach from the ports is a wake pulse that carries several waiters at once. To get there, the cell must be filled to full or drained to empty. Then several blocking accesses with different IDs must land on it before any access that is not blocked.

A directed prologue builds exactly that case twice:
- once on the full side, with waiters 5 and 9 released by a pop;
- once on the empty side, with waiter 3 released by a push.

After the prologue, a long random run biases the views toward the empty/full views and spreads IDs over all 64 values. This keeps the cell oscillating across both boundaries. It also mixes in control writes that force E or F out of step with the occupancy.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

  localparam logic [2:0] VIEW_RAW  = 3'd0;
  localparam logic [2:0] VIEW_CTRL = 3'd1;
  localparam logic [2:0] VIEW_SYNC = 3'd2;
  localparam logic [2:0] VIEW_TRY  = 3'd3;

  localparam int CW_DEPTH_LSB = 28;
  localparam int CW_OCC_LSB   = 18;
  localparam int CW_MODE_BIT  = 17;
  localparam int CW_T_BIT     = 16;
  localparam int CW_F_BIT     = 1;
  localparam int CW_E_BIT     = 0;

  typedef struct packed {
    logic t;
    logic f;
    logic e;
  } tag_t;

  typedef struct packed {
    logic raw_rd;
    logic raw_wr;
    logic ctl_rd;
    logic ctl_wr;
    logic ef_rd;
    logic ef_wr;
    logic blocked;
  } op_t;

endpackage

// File: rtl/tfc_decode.sv
module tfc_decode
  import tfc_pkg::*;
#(
  parameter bit FIFO_EN = 1'b1
) (
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [2:0] req_view,
  input  tag_t       tag_cur,
  output op_t        op
);

  logic is_ef;
  logic is_sync;

  always_comb begin
    is_ef   = req_valid && FIFO_EN && (req_view == VIEW_SYNC || req_view == VIEW_TRY);
    is_sync = (req_view == VIEW_SYNC);
    op.raw_rd  = req_valid && !req_write && (req_view == VIEW_RAW);
    op.raw_wr  = req_valid &&  req_write && (req_view == VIEW_RAW) && FIFO_EN;
    op.ctl_rd  = req_valid && !req_write && (req_view == VIEW_CTRL);
    op.ctl_wr  = req_valid &&  req_write && (req_view == VIEW_CTRL);
    op.ef_rd   = is_ef && !req_write;
    op.ef_wr   = is_ef &&  req_write;
    op.blocked = is_ef && is_sync && (req_write ? tag_cur.f : tag_cur.e);
  end

endmodule

// File: rtl/tfc_store.sv
module tfc_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] ent_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/tfc_tags.sv
module tfc_tags
  import tfc_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter bit FIFO_EN = 1'b1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_t              op,
  input  tag_t             ctl_wtag,
  output tag_t             tag_q,
  output logic [IDX_W-1:0] head_q,
  output logic [OCC_W-1:0] occ_q,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);

  tag_t             tag_n;
  logic [IDX_W-1:0] head_n;
  logic [OCC_W-1:0] occ_n;
  logic             upd_en;
  logic [IDX_W-1:0] tail_idx;

  assign tail_idx = head_q + occ_q[IDX_W-1:0];

  always_comb begin
    tag_n  = tag_q;
    head_n = head_q;
    occ_n  = occ_q;
    wr_en  = 1'b0;
    wr_idx = tail_idx;
    upd_en = op.ctl_wr | op.raw_wr | op.ef_rd | op.ef_wr;

    if (op.ctl_wr) begin
      tag_n = ctl_wtag;
      if (ctl_wtag.e) occ_n = '0;
    end

    if (op.raw_wr && occ_q != '0) begin
      wr_en  = 1'b1;
      wr_idx = tail_idx - IDX_W'(1);
    end

    if (op.ef_rd) begin
      tag_n.f = 1'b0;
      if (!op.blocked) begin
        if (occ_q != '0) begin
          head_n = head_q + IDX_W'(1);
          occ_n  = occ_q - OCC_W'(1);
        end
        if (occ_q <= OCC_W'(1)) tag_n.e = 1'b1;
      end
    end

    if (op.ef_wr) begin
      tag_n.e = 1'b0;
      if (!op.blocked) begin
        if (occ_q < OCC_W'(DEPTH)) begin
          wr_en = 1'b1;
          occ_n = occ_q + OCC_W'(1);
        end
        if (occ_q >= OCC_W'(DEPTH - 1)) tag_n.f = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '{t: 1'b0, f: 1'b0, e: FIFO_EN};
      head_q <= '0;
      occ_q  <= '0;
    end else if (upd_en) begin
      tag_q  <= tag_n;
      head_q <= head_n;
      occ_q  <= occ_n;
    end
  end

endmodule

// File: rtl/tfc_waiters.sv
module tfc_waiters #(
  parameter int REQ_N = 64,
  localparam int ID_W = $clog2(REQ_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             park,
  input  logic             release_all,
  input  logic [ID_W-1:0]  req_id,
  output logic [REQ_N-1:0] wake_q
);

  logic [REQ_N-1:0] wait_q;
  logic [REQ_N-1:0] wait_n;
  logic [REQ_N-1:0] wake_n;
  logic             wait_en;

  always_comb begin
    wait_n  = wait_q;
    wake_n  = '0;
    wait_en = park | release_all;
    if (park) begin
      wait_n = wait_q | (REQ_N'(1) << req_id);
    end else if (release_all) begin
      wake_n = wait_q;
      wait_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      wake_q <= '0;
    end else begin
      wake_q <= wake_n;
      if (wait_en) wait_q <= wait_n;
    end
  end

endmodule

// File: rtl/tagged_fifo_cell.sv
module tagged_fifo_cell
  import tfc_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 64,
  parameter int REQ_N   = 64,
  parameter bit FIFO_EN = 1'b1,
  localparam int ID_W = $clog2(REQ_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_view,
  input  logic [ID_W-1:0]   req_id,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_block,
  output logic [REQ_N-1:0]  wake_mask
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);

  op_t              op;
  tag_t             tag_q;
  tag_t             ctl_wtag;
  logic [IDX_W-1:0] head_q;
  logic [OCC_W-1:0] occ_q;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] rdata_n;

  assign ctl_wtag = '{t: req_wdata[CW_T_BIT], f: req_wdata[CW_F_BIT], e: req_wdata[CW_E_BIT]};

  tfc_decode #(.FIFO_EN(FIFO_EN)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_view  (req_view),
    .tag_cur   (tag_q),
    .op        (op)
  );

  tfc_tags #(.DEPTH(DEPTH), .FIFO_EN(FIFO_EN)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .ctl_wtag (ctl_wtag),
    .tag_q    (tag_q),
    .head_q   (head_q),
    .occ_q    (occ_q),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx)
  );

  tfc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (req_wdata),
    .rd_idx  (head_q),
    .rd_data (rd_data)
  );

  tfc_waiters #(.REQ_N(REQ_N)) u_wait (
    .clk         (clk),
    .rst_n       (rst_n),
    .park        (op.blocked),
    .release_all ((op.ef_rd | op.ef_wr) & ~op.blocked),
    .req_id      (req_id),
    .wake_q      (wake_mask)
  );

  always_comb begin
    ctl_word = '0;
    ctl_word[CW_DEPTH_LSB +: 4]  = FIFO_EN ? 4'(IDX_W) : 4'd0;
    ctl_word[CW_OCC_LSB +: OCC_W] = occ_q;
    ctl_word[CW_MODE_BIT]        = FIFO_EN;
    ctl_word[CW_T_BIT]           = tag_q.t;
    ctl_word[CW_F_BIT]           = tag_q.f;
    ctl_word[CW_E_BIT]           = tag_q.e;

    rdata_n = '0;
    if (op.ctl_rd) begin
      rdata_n = ctl_word;
    end else if (op.raw_rd && FIFO_EN) begin
      rdata_n = rd_data;
    end else if (op.ef_rd && !op.blocked && occ_q != '0) begin
      rdata_n = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_block <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_block <= op.blocked;
      rsp_rdata <= rdata_n;
    end
  end

endmodule

// File: rtl/tfc_checker.sv
module tfc_checker
  import tfc_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int REQ_N   = 64,
  parameter bit FIFO_EN = 1'b1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_view,
  input logic             rsp_valid,
  input logic             rsp_block,
  input logic [REQ_N-1:0] wake_mask,
  input logic [OCC_W-1:0] occ
);

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_block_sync_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_block |-> $past(req_valid && req_view == VIEW_SYNC));

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_mask) |=> (wake_mask == '0));

  assert_wake_not_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_mask) |-> !rsp_block);

  generate
    if (!FIFO_EN) begin : g_plain
      assert_plain_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_block && (wake_mask == '0));
    end
  endgenerate

endmodule

bind tagged_fifo_cell tfc_checker #(
  .DEPTH(DEPTH), .REQ_N(REQ_N), .FIFO_EN(FIFO_EN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_view  (req_view),
  .rsp_valid (rsp_valid),
  .rsp_block (rsp_block),
  .wake_mask (wake_mask),
  .occ       (occ_q)
);

// File: tb/sim_tagged_fifo_cell.sv
`timescale 1ns/1ps
module sim_tagged_fifo_cell;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [2:0]  req_view;
  logic [5:0]  req_id;
  logic [63:0] req_wdata;
  logic        v0, b0, v1, b1;
  logic [63:0] r0, r1, w0, w1;

  always #4 clk = ~clk;

  tagged_fifo_cell u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
    .rsp_valid(v0), .rsp_rdata(r0), .rsp_block(b0), .wake_mask(w0));

  tagged_fifo_cell #(.FIFO_EN(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_write(req_write), .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
    .rsp_valid(v1), .rsp_rdata(r1), .rsp_block(b1), .wake_mask(w1));

  int nchk = 0, nfail = 0;

  // reference state: FIFO cell (m*) and plain cell (n*)
  logic [63:0] q[$];
  bit mE, mF, mT, nE, nF, nT;
  logic [63:0] mW;
  // expected response
  bit xv, xb, xchk;
  logic [63:0] xr, xw, yr;
  string xtag;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check("R11", "rsp_valid", 64'(v0), 64'(xv));
    check("R10", "plain rsp_valid", 64'(v1), 64'(xv));
    if (xv) begin
      if (xchk) check(xtag, "rdata", r0, xr);
      if (xtag == "R1") check("R1", "reset control word", r0, 64'h3002_0001);
      check(xtag, "block", 64'(b0), 64'(xb));
      check("R10", "plain rdata", r1, yr);
    end
    check("R7", "wake_mask", w0, xw);
    check("R10", "plain block", 64'(b1), 64'd0);
    check("R10", "plain wake", w1, 64'd0);
  endtask

  task automatic model(bit w, int v, int id, logic [63:0] d);
    xv = 1; xb = 0; xchk = 1; xr = '0; xw = '0; yr = '0; xtag = "R11";
    case (v)
      0: if (!w) begin
           xtag = "R8";
           if (q.size() > 0) xr = q[0]; else xchk = 0;
         end else begin
           xtag = "R9";
           if (q.size() > 0) q[q.size()-1] = d;
         end
      1: if (!w) begin
           xtag = "R2";
           xr = (64'd3 << 28) | (64'(q.size()) << 18) | (64'd1 << 17) |
                (64'(mT) << 16) | (64'(mF) << 1) | 64'(mE);
           yr = (64'(nT) << 16) | (64'(nF) << 1) | 64'(nE);
         end else begin
           xtag = "R2";
           mT = d[16]; mF = d[1]; mE = d[0];
           nT = d[16]; nF = d[1]; nE = d[0];
           if (d[0]) q.delete();
         end
      2, 3: if (!w) begin
           mF = 0;
           if (v == 2 && mE) begin
             xtag = "R6"; xb = 1; mW |= (64'd1 << id);
           end else begin
             xtag = "R4"; xw = mW; mW = '0;
             if (q.size() > 0) xr = q.pop_front();
             if (q.size() == 0) mE = 1;
           end
         end else begin
           mE = 0;
           if (v == 2 && mF) begin
             xtag = "R5"; xb = 1; mW |= (64'd1 << id);
           end else begin
             xtag = "R3"; xw = mW; mW = '0;
             if (q.size() < 8) q.push_back(d);
             if (q.size() == 8) mF = 1;
           end
         end
      default: ;
    endcase
  endtask

  task automatic op(bit w, int v, int id, logic [63:0] d);
    @(negedge clk);
    compare();
    req_valid = 1; req_write = w; req_view = 3'(v); req_id = 6'(id); req_wdata = d;
    model(w, v, id, d);
  endtask

  task automatic idle();
    @(negedge clk);
    compare();
    req_valid = 0; req_write = 0; req_view = 0; req_id = 0; req_wdata = '0;
    xv = 0; xb = 0; xw = '0; xr = '0; yr = '0; xchk = 0; xtag = "R11";
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_view = 0; req_id = 0; req_wdata = '0;
    mE = 1; mF = 0; mT = 0; nE = 0; nF = 0; nT = 0; mW = '0;
    xv = 0; xb = 0; xw = '0; xr = '0; yr = '0; xchk = 0; xtag = "R11";
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset control word
    op(0, 1, 0, 0);
    xtag = "R1";
    idle();
    // R3/R8/R9: push, peek, overwrite newest
    op(1, 3, 1, 64'h11);
    op(1, 3, 1, 64'h22);
    op(1, 2, 1, 64'h33);
    op(0, 0, 0, 0);
    op(1, 0, 0, 64'hAB);
    op(0, 1, 0, 0);
    op(0, 3, 2, 0);
    // fill to full, overflow drop, blocked writers 5 and 9
    for (int i = 0; i < 7; i++) op(1, 3, 1, 64'(100 + i));
    op(1, 3, 1, 64'hDEAD);
    op(1, 2, 5, 64'hBEEF);
    op(1, 2, 9, 64'hBEEF);
    op(0, 1, 0, 0);
    op(0, 3, 4, 0);     // R7: wakes 5 and 9
    // drain, wrap, blocked reader 3, push wakes it
    for (int i = 0; i < 9; i++) op(0, 3, 2, 0);
    op(0, 2, 3, 0);
    op(0, 0, 0, 0);
    op(1, 0, 0, 64'h77);  // R9: ignored when empty
    op(1, 3, 6, 64'h55);
    op(0, 0, 0, 0);
    // R2: control write with E=1 resets occupancy; T/F writes
    op(1, 3, 1, 64'h66);
    op(1, 1, 0, 64'h0001_0003);
    op(0, 1, 0, 0);
    op(1, 1, 0, 64'h0);
    op(0, 1, 0, 0);
    // R11: unused views
    op(1, 6, 0, 64'h1234);
    op(0, 5, 0, 0);
    op(0, 1, 0, 0);
    // random run
    for (int i = 0; i < 4000; i++) begin
      int r, v;
      r = int'($urandom % 10);
      if (r == 0) idle();
      else begin
        r = int'($urandom % 12);
        v = (r == 0) ? 0 : (r == 1) ? 1 : (r < 7) ? 2 : (r < 11) ? 3 : 4 + int'($urandom % 4);
        op(bit'($urandom % 2), v, int'($urandom % 64), {$urandom, $urandom});
      end
    end
    idle();
    idle();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule